// File: doc/BRIEF.md
# Early-Reset Capacitor Switching Controller

This controller sequences the bottom-plate switch settings of a differential, binary-weighted capacitor DAC inside a successive-approximation converter. A one-cycle start pulse, taken only while the block is idle, begins a conversion. After that the block reads one comparator decision on every clock edge, for N edges. After each decision except the last, it updates a three-level drive code for every capacitor on the positive and negative halves. The two halves are always driven as mirror images, so the summing node keeps its common-mode level.

The switching follows an early-reset rule. The first decision fixes a single polarity, and every capacitor that is ever switched is driven with that polarity. A later decision that agrees with the first adds the next smaller capacitor and leaves the earlier ones as they are. A later decision that disagrees with the first sends the most recently switched capacitor back to common-mode and drives the next smaller capacitor. This works because each capacitor weighs twice the next one, so the charge seen by the comparator equals that of a plain binary search. The raw decisions therefore form the output code directly, most significant first.

Capacitor c (0 is the largest) carries relative weight 2^(N-2-c) and occupies bits [2c+1:2c] of each drive vector. A decision of 1 means the positive summing node is above the negative one.

Top module: `erms_sar_ctrl`

## Requirements
- R1: After reset, and in every cycle in which busy_o is low, every drive code on both halves is common-mode (00), and done_o is low. code_o is zero after reset.
- R2: Drive codes use 00 for common-mode, 01 for supply and 10 for ground, and 11 never appears. In every cycle each negative-half code is the mirror of the positive-half code of the same capacitor: common-mode pairs with common-mode, supply with ground.
- R3: In the first conversion cycle, the cycle after the start edge, busy_o is high and all capacitors stay at common-mode.
- R4: After the first decision, capacitor 0 is driven on the positive half to ground if that decision was 1 and to supply if it was 0. Every capacitor switched later in the conversion uses this same polarity.
- R5: Take a decision at step k (1 ≤ k ≤ N-2) that equals the first decision. After it, the capacitors already driven keep their codes and capacitor k is driven as well.
- R6: Take a decision at step k (1 ≤ k ≤ N-2) that differs from the first decision. After it, capacitor k-1 returns to common-mode and capacitor k is driven.
- R7: A conversion takes N decision edges after the start edge. done_o is high for exactly one cycle, the one after the N-th decision edge. In that cycle busy_o is low and all drives are common-mode.
- R8: When done_o is high, code_o holds the N decisions with the first in the MSB, which is the conventional binary-search code of the input. code_o keeps that value until the next conversion completes.
- R9: A start pulse while busy_o is high is ignored: the running conversion keeps its step sequence, drive codes and completion cycle.
- R10: A start pulse in the cycle where done_o is high begins a new conversion at once, with the same timing as a start from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| cmp_i | input | 1 | Comparator decision, 1 when positive node is higher |
| busy_o | output | 1 | Conversion in progress |
| pos_drv_o | output | 2*(N-1) | Positive-half drive codes, capacitor c at [2c+1:2c] |
| neg_drv_o | output | 2*(N-1) | Negative-half drive codes, same layout |
| code_o | output | N | Conversion result, first decision in MSB |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench closes the loop with a behavioural comparator. It forms the residue from the input and the actual drive codes, so any wrong switching step shows up both as a per-cycle drive mismatch and as a wrong final code. The input codes are chosen to separate the two switching branches. A lone top bit followed by zeros resets on every step. All ones and all zeros never reset. Alternating patterns flip between the branches on every step. The values one step from each end probe the last capacitor and the final decision. Random codes, a start pulse in mid-conversion and back-to-back starts in the done cycle complete the stimulus, and they tell apart a correct step sequence from one that restarts or stalls.

// File: rtl/erms_pkg.sv
package erms_pkg;

   typedef enum logic [1:0] {
      LVL_MID = 2'b00,
      LVL_HI  = 2'b01,
      LVL_LO  = 2'b10
   } lvl_e;

   function automatic logic [1:0] lvl_swap(input logic [1:0] lvl);
      case (lvl)
         2'b01:   return 2'b10;
         2'b10:   return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/erms_seq.sv
module erms_seq #(
   parameter int unsigned N            = 10,
   parameter bit          ONEHOT_PHASE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   output logic         busy_o,
   output logic [N-1:0] phase_o
);

   localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;

   logic busy_q;

   generate
      if (N < 3) begin : g_bad_n
         $error("erms_seq: N must be at least 3");
      end

      if (ONEHOT_PHASE) begin : g_ring
         logic [N-1:0] ring_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ring_q <= '0;
            end else if (!busy_q) begin
               if (start_i) ring_q <= N'(1);
            end else begin
               ring_q <= {ring_q[N-2:0], 1'b0};
            end
         end
         assign phase_o = ring_q;
      end else begin : g_count
         logic [SW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!busy_q) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         always_comb begin
            phase_o = '0;
            if (busy_q) phase_o[cnt_q] = 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (!busy_q) begin
         busy_q <= start_i;
      end else if (phase_o[N-1]) begin
         busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;

   assert_phase_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ($countones(phase_o) == 1));

   assert_phase_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (phase_o == '0));

   assert_step_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !phase_o[N-1]) |=> (busy_q && (phase_o == ($past(phase_o) << 1))));

endmodule

// File: rtl/erms_cap_bank.sv
module erms_cap_bank #(
   parameter int unsigned N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         busy_i,
   input  logic         dec_i,
   input  logic [N-1:0] phase_i,
   output logic [N-2:0] on_o,
   output logic         pol_o
);

   localparam int unsigned NCAP = N - 1;

   logic pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q <= 1'b0;
      end else if (busy_i && phase_i[0]) begin
         pol_q <= dec_i;
      end
   end

   generate
      for (genvar c = 0; c < NCAP; c++) begin : g_cap
         logic act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q <= 1'b0;
            end else if (busy_i) begin
               if (phase_i[N-1]) begin
                  act_q <= 1'b0;
               end else if (phase_i[c]) begin
                  act_q <= 1'b1;
               end else if (phase_i[c+1] && (dec_i != pol_q)) begin
                  act_q <= 1'b0;
               end
            end
         end
         assign on_o[c] = act_q;
      end
   endgenerate

   assign pol_o = pol_q;

   assert_first_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && phase_i[0]) |=> ($countones(on_o) == 1) && on_o[0]);

   assert_keep_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !phase_i[0] && !phase_i[N-1] && (dec_i == pol_o))
      |=> ($countones(on_o) == $past($countones(on_o)) + 1));

   assert_early_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !phase_i[0] && !phase_i[N-1] && (dec_i != pol_o))
      |=> ($countones(on_o) == $past($countones(on_o))));

   assert_pol_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !phase_i[0]) |=> $stable(pol_o));

endmodule

// File: rtl/erms_drv_map.sv
module erms_drv_map
   import erms_pkg::*;
#(
   parameter int unsigned NCAP = 9
) (
   input  logic [NCAP-1:0]   on_i,
   input  logic              pol_i,
   output logic [2*NCAP-1:0] pos_o,
   output logic [2*NCAP-1:0] neg_o
);

   generate
      for (genvar c = 0; c < NCAP; c++) begin : g_map
         lvl_e pos_lvl;
         lvl_e neg_lvl;
         always_comb begin
            pos_lvl = LVL_MID;
            neg_lvl = LVL_MID;
            if (on_i[c]) begin
               pos_lvl = pol_i ? LVL_LO : LVL_HI;
               neg_lvl = pol_i ? LVL_HI : LVL_LO;
            end
         end
         assign pos_o[2*c +: 2] = pos_lvl;
         assign neg_o[2*c +: 2] = neg_lvl;
      end
   endgenerate

endmodule

// File: rtl/erms_collect.sv
module erms_collect #(
   parameter int unsigned N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         busy_i,
   input  logic         last_i,
   input  logic         dec_i,
   output logic [N-1:0] code_o,
   output logic         done_o
);

   logic [N-1:0] sh_q;
   logic [N-1:0] code_q;
   logic         done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         code_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= busy_i && last_i;
         if (busy_i) sh_q <= {sh_q[N-2:0], dec_i};
         if (busy_i && last_i) code_q <= {sh_q[N-2:0], dec_i};
      end
   end

   assign code_o = code_q;
   assign done_o = done_q;

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_i && last_i) |=> $stable(code_q));

endmodule

// File: rtl/erms_sar_ctrl.sv
module erms_sar_ctrl
   import erms_pkg::*;
#(
   parameter int unsigned N            = 10,
   parameter bit          ONEHOT_PHASE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               cmp_i,
   output logic               busy_o,
   output logic [2*(N-1)-1:0] pos_drv_o,
   output logic [2*(N-1)-1:0] neg_drv_o,
   output logic [N-1:0]       code_o,
   output logic               done_o
);

   localparam int unsigned NCAP = N - 1;

   logic            busy;
   logic [N-1:0]    phase;
   logic [NCAP-1:0] cap_on;
   logic            pol;

   erms_seq #(.N(N), .ONEHOT_PHASE(ONEHOT_PHASE)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .busy_o  (busy),
      .phase_o (phase)
   );

   erms_cap_bank #(.N(N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_i  (busy),
      .dec_i   (cmp_i),
      .phase_i (phase),
      .on_o    (cap_on),
      .pol_o   (pol)
   );

   erms_drv_map #(.NCAP(NCAP)) u_map (
      .on_i  (cap_on),
      .pol_i (pol),
      .pos_o (pos_drv_o),
      .neg_o (neg_drv_o)
   );

   erms_collect #(.N(N)) u_collect (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy),
      .last_i (phase[N-1]),
      .dec_i  (cmp_i),
      .code_o (code_o),
      .done_o (done_o)
   );

   assign busy_o = busy;

   assert_idle_mid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((pos_drv_o == '0) && (neg_drv_o == '0)));

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy);

   generate
      for (genvar c = 0; c < NCAP; c++) begin : g_chk
         assert_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
            neg_drv_o[2*c +: 2] == lvl_swap(pos_drv_o[2*c +: 2]));
         assert_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pos_drv_o[2*c +: 2] != 2'b11);
      end
   endgenerate

endmodule

// File: tb/erms_sar_ctrl_tb.sv
module erms_sar_ctrl_tb;

   localparam int N    = 10;
   localparam int NCAP = N - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              cmp;
   logic              busy;
   logic [2*NCAP-1:0] pos_drv;
   logic [2*NCAP-1:0] neg_drv;
   logic [N-1:0]      code;
   logic              done;
   int                vin = 1;
   int                total = 0;
   int                bad = 0;

   always #10 clk = ~clk;

   erms_sar_ctrl #(.N(N)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .cmp_i     (cmp),
      .busy_o    (busy),
      .pos_drv_o (pos_drv),
      .neg_drv_o (neg_drv),
      .code_o    (code),
      .done_o    (done)
   );

   // comparator model: residue = input plus the charge placed by the positive half
   always_comb begin
      int r;
      r = vin;
      for (int c = 0; c < NCAP; c++) begin
         if (pos_drv[2*c +: 2] == 2'b01) r = r + (1 << (N - 1 - c));
         else if (pos_drv[2*c +: 2] == 2'b10) r = r - (1 << (N - 1 - c));
      end
      cmp = (r > 0);
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic run_conv(input int c_in, input bit mid_start, input bit pre_started, input bit chain);
      bit [N-1:0] cv;
      logic [2*NCAP-1:0] ep, en;
      cv  = N'(c_in);
      vin = 2 * c_in - (1 << N) + 1;
      if (!pre_started) begin
         @(negedge clk);
         start = 1'b1;
      end
      for (int j = 0; j < N; j++) begin
         string tag;
         @(negedge clk);
         start = mid_start && (j == 2 || j == 6);   // R9: ignored mid-conversion pulses
         ep = '0;
         en = '0;
         for (int c = 0; c < NCAP; c++) begin
            bit act;
            act = (c < j) && !((c + 1 < j) && (cv[N-2-c] != cv[N-1]));
            if (act) begin
               ep[2*c +: 2] = cv[N-1] ? 2'b10 : 2'b01;
               en[2*c +: 2] = cv[N-1] ? 2'b01 : 2'b10;
            end
         end
         if (j == 0) tag = "R3 first cycle";
         else if (j == 1) tag = "R4 first switch";
         else if (cv[N-j] != cv[N-1]) tag = "R6 early reset";
         else tag = "R5 keep and add";
         check(busy === 1'b1 && done === 1'b0, {tag, " busy"}, {busy, done}, 2'b10);
         check(pos_drv === ep, {tag, " pos drive"}, pos_drv, ep);
         check(neg_drv === en, {tag, " R2 neg drive"}, neg_drv, en);
      end
      @(negedge clk);
      start = chain;                                // R10: start in done cycle
      check(done === 1'b1 && busy === 1'b0, "R7 done pulse", {done, busy}, 2'b10);
      check(pos_drv === '0 && neg_drv === '0, "R7 R1 drives mid at done", pos_drv, 0);
      check(code === cv, "R8 code", code, cv);
      if (!chain) begin
         @(negedge clk);
         check(done === 1'b0, "R7 done one cycle", done, 0);
         check(code === cv, "R8 code held", code, cv);
         check(pos_drv === '0 && neg_drv === '0, "R1 idle drives", pos_drv, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {busy, done}, 0);
      check(pos_drv === '0 && neg_drv === '0, "R1 reset drives", pos_drv, 0);
      check(code === '0, "R1 reset code", code, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pos_drv === '0 && busy === 1'b0, "R1 idle after reset", pos_drv, 0);

      run_conv(512, 1'b0, 1'b0, 1'b0);     // top bit then zeros: reset every step
      run_conv(511, 1'b0, 1'b0, 1'b0);
      run_conv(0, 1'b0, 1'b0, 1'b0);       // never resets
      run_conv(1023, 1'b0, 1'b0, 1'b0);
      run_conv(10'h2AA, 1'b0, 1'b0, 1'b0); // alternating
      run_conv(10'h155, 1'b0, 1'b0, 1'b0);
      run_conv(1, 1'b0, 1'b0, 1'b0);
      run_conv(1022, 1'b0, 1'b0, 1'b0);
      run_conv(10'h3A5, 1'b1, 1'b0, 1'b0); // R9
      run_conv(10'h0F0, 1'b0, 1'b0, 1'b1); // R10 chain
      run_conv(10'h30F, 1'b0, 1'b1, 1'b1);
      run_conv(10'h1C3, 1'b1, 1'b1, 1'b0);
      for (int k = 0; k < 30; k++) begin
         run_conv(int'($urandom_range(0, (1 << N) - 1)), k[0], 1'b0, 1'b0);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule